// File: doc/BRIEF.md
# Gated Acquisition Sample Controller

The controller sits between a sample source and sample storage and picks which incoming samples are written, based on a gate level. While the gate is high, samples pass. A history ring keeps recent gate-low samples, so that up to a programmed number of samples from just before each gate rise are stored ahead of the live ones. After the gate falls, a programmed number of extra samples is still stored. The last stored sample of each segment carries a segment-end flag.

Two run modes exist. In memory mode a total sample budget ends the run as soon as that many samples have left the block, even in the middle of a gate segment. In streaming mode the run ends after a programmed number of segments, and a count of zero means the run only ends on a software stop. A start strobe checks the configuration and begins a run. A stop strobe aborts a run at once.

Samples are counted only in cycles where `in_valid` is high. The gate is sampled together with each valid sample. The sample that shows the gate low for the first time always belongs to the segment. The post-gate count adds samples after it.

Top module: `gated_acq_ctrl`

## Requirements
- R1: While busy, every valid sample taken with the gate high is output once, in arrival order. Cycles with `in_valid` low carry no sample, and nothing is output while idle.
- R2: At a gate rise, up to `cfg_pre` gate-low samples received just before it are output first, oldest first, followed by the rising sample.
- R3: If fewer than `cfg_pre` history samples are available at a gate rise (just after start, or while the previous segment is still draining), only those present are output.
- R4: A segment holds the first gate-low sample plus `cfg_post` further samples. `out_last` is high with exactly the final one of these.
- R5: A gate rise inside the post-gate window continues the segment: no `out_last` in between and no sample repeated.
- R6: A start with `cfg_pre` above PRE_MAX, or with memory mode (`cfg_stream`=0) and `cfg_budget`=0, sets `cfg_err` and leaves `busy` low. A valid start clears `cfg_err`.
- R7: In memory mode exactly `cfg_budget` samples are output. The last of them carries `out_last` even if the gate is still high. `done` rises in that same cycle and `busy` falls.
- R8: In streaming mode (`cfg_stream`=1) with `cfg_gates`=N>0, `done` rises with the `out_last` of the Nth segment and `busy` falls. With N=0 the run continues until stopped.
- R9: A stop makes `busy` and `out_valid` low from the next cycle on, discards pending samples and leaves `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stream | input | 1 | 0 = memory mode, 1 = streaming mode |
| cfg_pre | input | PRE_W | Samples stored before each gate rise |
| cfg_post | input | CNT_W | Extra samples stored after the first gate-low sample |
| cfg_budget | input | CNT_W | Total samples per run in memory mode |
| cfg_gates | input | CNT_W | Segments per run in streaming mode, 0 = unlimited |
| start | input | 1 | Start strobe |
| stop | input | 1 | Software stop strobe |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DW | Input sample |
| gate | input | 1 | Gate level, sampled with each valid sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DW | Output sample |
| out_last | output | 1 | Last sample of a segment |
| busy | output | 1 | Run in progress |
| done | output | 1 | An end condition was met |
| cfg_err | output | 1 | Last start was rejected |

## Verification
Two pairs of functions can fall into the same cycle. The budget cut can land on a sample in the middle of a gate. Here the segment-end flag, `done` and the fall of `busy` must all appear with the very sample that uses up the budget. This is provoked by a long gate and a small budget, and judged by the set of output samples and their flags. A gate rise can also arrive while the post-gate counter is running. This is provoked by two gate pulses closer together than the post window, and judged by a single `out_last` and a gapless run of sample indices.

// File: rtl/gacq_pkg.sv
// Shared types for the gated acquisition controller.
// Assumes: nothing beyond a 1-bit mode select at the top level.
package gacq_pkg;
    typedef enum logic {
        RUN_MEM    = 1'b0,
        RUN_STREAM = 1'b1
    } run_mode_e;
endpackage

// File: rtl/gacq_ring.sv
// Ring buffer holding pre-gate history and committed (to-be-output) samples.
// The committed samples sit at the head, and history samples follow them.
// Assumes: drop is only asserted with no committed entries, pop only with
// committed entries, and the occupancy never exceeds DEPTH (guaranteed by top).
module gacq_ring #(
    parameter int DW    = 16,
    parameter int DEPTH = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    input  logic          push_commit,
    input  logic          commit_all,
    input  logic          pop,
    input  logic          drop,
    output logic [DW-1:0] head_data,
    output logic          head_last,
    output logic [CW-1:0] n_total,
    output logic [CW-1:0] n_commit
);
    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_last, push_data};
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            n_total  <= '0;
            n_commit <= '0;
        end else begin
            if (push)        wr_ptr <= step(wr_ptr);
            if (pop || drop) rd_ptr <= step(rd_ptr);
            n_total  <= n_total + CW'(push) - CW'(pop || drop);
            n_commit <= (commit_all ? n_total : n_commit)
                        + CW'(push && push_commit) - CW'(pop);
        end
    end

    assign {head_last, head_data} = mem[rd_ptr];

    p_pop_committed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (n_commit != '0));
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        n_total <= CW'(DEPTH));
    p_commit_within_r2: assert property (@(posedge clk) disable iff (!rst_n)
        n_commit <= n_total);
endmodule

// File: rtl/gacq_endrule.sv
// End-of-run rules, evaluated on samples as they leave the block.
// Memory mode: the sample that uses up the budget ends the run and its segment.
// Streaming mode: the segment end numbered cfg_gates ends the run (0 = never).
// Assumes: clear is pulsed at every accepted start.
module gacq_endrule #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             stream,
    input  logic [CNT_W-1:0] budget,
    input  logic [CNT_W-1:0] gates,
    input  logic             take,
    input  logic             take_last,
    output logic             seg_end,
    output logic             final_take
);
    logic [CNT_W-1:0] n_out, n_seg;
    logic             budget_hit, gates_hit;

    // Decide whether the outgoing sample closes its segment or the run.
    always_comb begin
        budget_hit = !stream && (n_out + CNT_W'(1) == budget);
        seg_end    = take_last || budget_hit;
        gates_hit  = stream && (gates != '0) && seg_end && (n_seg + CNT_W'(1) == gates);
        final_take = take && (budget_hit || gates_hit);
    end

    // Count output samples and completed segments of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            n_out <= '0;
            n_seg <= '0;
        end else if (take) begin
            n_out <= n_out + CNT_W'(1);
            if (seg_end) n_seg <= n_seg + CNT_W'(1);
        end
    end

    p_budget_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !stream) |-> (n_out < budget));
    p_gate_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && stream && gates != '0) |-> (n_seg < gates));
endmodule

// File: rtl/gated_acq_ctrl.sv
// Gated acquisition controller top.
// It classifies each valid sample (history, gate rise, in-gate, post-gate or
// discard), keeps it in the ring and releases committed samples one per cycle.
// Assumes: configuration inputs are held stable while busy. History is only
// gathered once the previous segment has drained from the ring.
module gated_acq_ctrl
    import gacq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int PRE_MAX = 8,
    parameter int CNT_W   = 32,
    localparam int PRE_W  = $clog2(PRE_MAX + 1) + 1,
    localparam int DEPTH  = PRE_MAX + 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_stream,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [CNT_W-1:0] cfg_budget,
    input  logic [CNT_W-1:0] cfg_gates,
    input  logic             start,
    input  logic             stop,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             gate,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             busy,
    output logic             done,
    output logic             cfg_err
);
    run_mode_e        mode;
    logic             running, in_seg, in_post;
    logic [CNT_W-1:0] post_left;
    logic             smp, rise, seg_hi, first_lo, post_lo, hist_in;
    logic             push, push_last, drop, take, bad_cfg, start_ok, flush;
    logic             seg_end, final_take, head_last;
    logic [DW-1:0]    head_data;
    logic [CW-1:0]    n_total, n_commit, n_hist;

    assign mode = run_mode_e'(cfg_stream);

    // Reject a configuration the history ring or budget cannot honour.
    always_comb begin
        bad_cfg  = (32'(cfg_pre) > PRE_MAX) || (mode == RUN_MEM && cfg_budget == '0);
        start_ok = start && !stop && !bad_cfg;
        flush    = stop || start_ok || final_take;
    end

    // Classify the incoming sample against the gate and the segment state.
    always_comb begin
        n_hist    = n_total - n_commit;
        smp       = running && in_valid;
        rise      = smp && !in_seg && gate;
        seg_hi    = smp && in_seg && gate;
        first_lo  = smp && in_seg && !gate && !in_post;
        post_lo   = smp && in_seg && !gate && in_post;
        hist_in   = smp && !in_seg && !gate && (n_commit == '0) && (cfg_pre != '0);
        push      = rise || seg_hi || first_lo || post_lo || hist_in;
        push_last = (first_lo && cfg_post == '0) || (post_lo && post_left == CNT_W'(1));
        drop      = hist_in && (32'(n_hist) >= 32'(cfg_pre));
        take      = running && (n_commit != '0);
    end

    gacq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (push),
        .push_data  (in_data),
        .push_last  (push_last),
        .push_commit(!hist_in),
        .commit_all (rise),
        .pop        (take),
        .drop       (drop),
        .head_data  (head_data),
        .head_last  (head_last),
        .n_total    (n_total),
        .n_commit   (n_commit)
    );

    gacq_endrule #(.CNT_W(CNT_W)) u_end (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .active    (running),
        .stream    (mode == RUN_STREAM),
        .budget    (cfg_budget),
        .gates     (cfg_gates),
        .take      (take),
        .take_last (head_last),
        .seg_end   (seg_end),
        .final_take(final_take)
    );

    // Register the outgoing sample and its segment-end flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= take && !stop && !start;
            out_data  <= head_data;
            out_last  <= take && !stop && !start && seg_end;
        end
    end

    // Run control and segment tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            done      <= 1'b0;
            cfg_err   <= 1'b0;
            in_seg    <= 1'b0;
            in_post   <= 1'b0;
            post_left <= '0;
        end else if (stop) begin
            running <= 1'b0;
            in_seg  <= 1'b0;
            in_post <= 1'b0;
        end else if (start) begin
            cfg_err <= bad_cfg;
            if (!bad_cfg) begin
                running <= 1'b1;
                done    <= 1'b0;
                in_seg  <= 1'b0;
                in_post <= 1'b0;
            end
        end else if (running) begin
            if (final_take) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
            if (rise) begin
                in_seg  <= 1'b1;
                in_post <= 1'b0;
            end else if (seg_hi) begin
                in_post <= 1'b0;
            end else if (first_lo) begin
                in_seg    <= (cfg_post != '0);
                in_post   <= (cfg_post != '0);
                post_left <= cfg_post;
            end else if (post_lo) begin
                post_left <= post_left - CNT_W'(1);
                if (post_left == CNT_W'(1)) begin
                    in_seg  <= 1'b0;
                    in_post <= 1'b0;
                end
            end
        end
    end

    assign busy = running;

    p_last_has_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    p_reject_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop && bad_cfg && !busy) |=> (cfg_err && !busy));
    p_done_with_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (out_valid && out_last));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !out_valid));
endmodule

// File: tb/test_gated_acq_ctrl.sv
`timescale 1ns/1ps
module test_gated_acq_ctrl;
    localparam int DW = 16, PRE_MAX = 8, CNT_W = 32;
    localparam int PRE_W = $clog2(PRE_MAX + 1) + 1;

    typedef struct packed {
        logic [4:0]  pre;
        logic [7:0]  post;
        logic        stream;
        logic [7:0]  budget;
        logic [7:0]  gates;
        logic [15:0] pat;
        logic [15:0] outm;
        logic [15:0] lastm;
        logic        dn;
    } vec_t;

    // Gate pattern bit i = gate with sample i (data = i); expected masks of output indices.
    localparam vec_t VECS [7] = '{
        '{5'd2, 8'd1, 1'b0, 8'd100, 8'd0, 16'h0070, 16'h01FC, 16'h0100, 1'b0},
        '{5'd0, 8'd0, 1'b0, 8'd100, 8'd0, 16'h030C, 16'h071C, 16'h0410, 1'b0},
        '{5'd1, 8'd2, 1'b0, 8'd4,   8'd0, 16'h03F8, 16'h003C, 16'h0020, 1'b1},
        '{5'd0, 8'd0, 1'b1, 8'd0,   8'd2, 16'h0432, 16'h0076, 16'h0044, 1'b1},
        '{5'd0, 8'd2, 1'b0, 8'd100, 8'd0, 16'h0024, 16'h01FC, 16'h0100, 1'b0},
        '{5'd8, 8'd0, 1'b1, 8'd0,   8'd0, 16'h3000, 16'h7FF0, 16'h4000, 1'b0},
        '{5'd5, 8'd0, 1'b0, 8'd100, 8'd0, 16'h0004, 16'h000F, 16'h0008, 1'b0}
    };
    localparam string TAGS [7] = '{"R2/R4", "R1/R4", "R7", "R8", "R5", "R2", "R3"};

    logic             clk = 1'b0, rst_n = 1'b0;
    logic             cfg_stream = 1'b0;
    logic [PRE_W-1:0] cfg_pre = '0;
    logic [CNT_W-1:0] cfg_post = '0, cfg_budget = '0, cfg_gates = '0;
    logic             start = 1'b0, stop = 1'b0, in_valid = 1'b0, gate = 1'b0;
    logic [DW-1:0]    in_data = '0;
    logic             out_valid, out_last, busy, done, cfg_err;
    logic [DW-1:0]    out_data;

    int checks = 0, failures = 0;
    bit ended = 0;
    logic [15:0] got_mask, got_last;
    int n_out, order_bad, prev_idx;

    gated_acq_ctrl #(.DW(DW), .PRE_MAX(PRE_MAX), .CNT_W(CNT_W)) i_gated_acq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_stream(cfg_stream), .cfg_pre(cfg_pre),
        .cfg_post(cfg_post), .cfg_budget(cfg_budget), .cfg_gates(cfg_gates),
        .start(start), .stop(stop), .in_valid(in_valid), .in_data(in_data),
        .gate(gate), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .busy(busy), .done(done), .cfg_err(cfg_err));

    always #10 clk = ~clk;

    // Output monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out = n_out + 1;
            if (out_data >= 16 || int'(out_data) <= prev_idx) order_bad = order_bad + 1;
            else begin
                got_mask[out_data[3:0]] = 1'b1;
                got_last[out_data[3:0]] = out_last;
            end
            prev_idx = int'(out_data);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_mask = '0; got_last = '0; n_out = 0; order_bad = 0; prev_idx = -1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic run_vec(input int k);
        vec_t v = VECS[k];
        cfg_pre = PRE_W'(v.pre); cfg_post = CNT_W'(v.post); cfg_stream = v.stream;
        cfg_budget = CNT_W'(v.budget); cfg_gates = CNT_W'(v.gates);
        clear_mon();
        pulse_start();
        check(busy && !cfg_err, TAGS[k], "started", {busy, cfg_err}, 2'b10);
        for (int i = 0; i < 16; i++) begin
            in_valid = 1'b1; gate = v.pat[i]; in_data = DW'(i);
            @(negedge clk);
        end
        in_valid = 1'b0; gate = 1'b0;
        repeat (20) @(negedge clk);
        check(got_mask == v.outm, TAGS[k], "output samples", got_mask, v.outm);
        check(got_last == v.lastm, TAGS[k], "segment ends", got_last, v.lastm);
        check(order_bad == 0, TAGS[k], "order", order_bad, 0);
        check(done == v.dn, TAGS[k], "done", done, v.dn);
        pulse_stop();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !busy && !done && !cfg_err, "R1", "reset state",
              {out_valid, busy, done, cfg_err}, 0);

        // R6: pre-gate count above the maximum is refused.
        cfg_pre = PRE_W'(PRE_MAX + 1); cfg_budget = 10; cfg_stream = 1'b0;
        pulse_start();
        check(cfg_err && !busy, "R6", "pre too large", {cfg_err, busy}, 2'b10);
        // R6: zero budget in memory mode is refused.
        cfg_pre = '0; cfg_budget = '0;
        pulse_start();
        check(cfg_err && !busy, "R6", "zero budget", {cfg_err, busy}, 2'b10);

        // Table of scenarios.
        for (int k = 0; k < 7; k++) run_vec(k);

        // R1: samples with in_valid low are ignored, even with the gate high.
        cfg_pre = '0; cfg_post = '0; cfg_stream = 1'b0; cfg_budget = 50;
        clear_mon();
        pulse_start();
        gate = 1'b1; in_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(n_out == 0, "R1", "invalid cycles", n_out, 0);
        gate = 1'b0;
        pulse_stop();

        // R9: stop in the middle of a gate, streaming with no segment limit.
        cfg_stream = 1'b1; cfg_gates = '0; cfg_pre = 5'd2;
        clear_mon();
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; gate = 1'b1; in_data = DW'(i);
            @(negedge clk);
        end
        stop = 1'b1; in_data = 6;
        @(negedge clk);
        stop = 1'b0;
        check(!busy && !out_valid, "R9", "stop takes effect", {busy, out_valid}, 0);
        clear_mon();
        for (int i = 7; i < 12; i++) begin
            in_data = DW'(i);
            @(negedge clk);
        end
        in_valid = 1'b0; gate = 1'b0;
        repeat (4) @(negedge clk);
        check(n_out == 0 && !done, "R9", "quiet after stop", {n_out[7:0], done}, 0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule